// File: doc/BRIEF.md
# Memory Decode Error Interrupt Capture

This block sits next to a memory controller's address decoders and records three kinds of fault: a bus-side decode error, an external-memory decode error and a lookup that hits an invalid page in the address remap table. Detecting the faults happens elsewhere. Each detector delivers a one-cycle pulse together with the address and the request status of the offending access.

For each source the block latches a pending bit. It captures the address and the request status of the first fault, and keeps them until software acknowledges that fault. A mask register enables each source separately onto a single interrupt line. The handler reads the pending bits and the captured registers. It then acknowledges every source it has serviced with one write-one-to-clear access.

Top module: `decerr_capture`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 0 (masked), every captured address and request status is 0, and `irq_o` is 0.
- R2: A pulse on `err_i[k]` sets `status_o[k]` in the cycle after the clock edge that samples it. Bit 0 is the bus decode error, bit 1 the external-memory decode error and bit 2 the invalid remap page.
- R3: When a pulse arrives while `status_o[k]` is 0, the address and request status offered with it appear on field k of `cap_addr_o` (bits k*ADDR_W and up) and of `cap_info_o` (bits k*INFO_W and up) after that edge.
- R4: While `status_o[k]` is 1, further pulses on source k leave its captured address and request status unchanged.
- R5: A cycle with `clr_we_i` high clears every pending bit whose `clr_data_i` bit is 1. Bits written 0 keep their value, and any number of bits may be cleared in one write.
- R6: When an error pulse and a clear for the same source fall in the same cycle, the pending bit is 1 afterwards.
- R7: `irq_o` is 1 exactly when at least one source has both its pending bit and its mask bit at 1. A mask bit of 1 means unmasked.
- R8: A cycle with `mask_we_i` high loads `mask_data_i` into `mask_o` after the edge. Masking does not stop a source from latching its pending bit or its capture.
- R9: Once a pending bit has been cleared, the next error on that source captures its own address and request status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | NUM_SRC | One-cycle error pulse per source |
| err_addr_i | input | NUM_SRC*ADDR_W | Faulting address per source |
| err_info_i | input | NUM_SRC*INFO_W | Faulting request status per source |
| clr_we_i | input | 1 | Write strobe for the pending-bit clear |
| clr_data_i | input | NUM_SRC | Write-one-to-clear data |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_data_i | input | NUM_SRC | New mask value (1 = unmasked) |
| status_o | output | NUM_SRC | Pending bits |
| mask_o | output | NUM_SRC | Mask register |
| cap_addr_o | output | NUM_SRC*ADDR_W | Captured addresses |
| cap_info_o | output | NUM_SRC*INFO_W | Captured request status |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions expect each error input to be valid at the sampling edge and its address and status to be stable there. They expect no X on the strobes after reset. Every error is treated as a single pulse that takes effect at the edge where it is sampled. The bench drives every input at the falling edge and holds it for exactly one cycle, so every pulse and every write meets these conditions. The bench also drives back-to-back errors on one source to reach the capture-hold case.

// File: rtl/decerr_pkg.sv
package decerr_pkg;
  localparam int unsigned NUM_SRC = 3;
  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_EXTMEM = 2'd1,
    SRC_REMAP  = 2'd2
  } decerr_src_e;
endpackage

// File: rtl/decerr_slot.sv
module decerr_slot #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INFO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [INFO_W-1:0] info_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [INFO_W-1:0] info_q;
  logic              take;

  assign take = err_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      // a fresh error beats a same-cycle clear
      pend_q <= err_i | (pend_q & ~clr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      info_q <= '0;
    end else if (take) begin
      addr_q <= addr_i;
      info_q <= info_i;
    end
  end

  assign pend_o = pend_q;
  assign addr_o = addr_q;
  assign info_o = info_q;

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> pend_q);
  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !pend_q) |=> (addr_q == $past(addr_i)) && (info_q == $past(info_i)));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> $stable(addr_q) && $stable(info_q));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !err_i) |=> !pend_q);
  assert_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
  assert_err_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && err_i) |=> pend_q);
endmodule

// File: rtl/decerr_irq.sv
module decerr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_data_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_data_i;
  end

  assign live   = pend_i & mask_q;
  assign irq_o  = |live;
  assign mask_o = mask_q;

  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !irq_o);
  assert_all_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !irq_o);
  assert_mask_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == $past(mask_data_i));
  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/decerr_capture.sv
module decerr_capture
  import decerr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INFO_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        err_i,
  input  logic [NUM_SRC*ADDR_W-1:0] err_addr_i,
  input  logic [NUM_SRC*INFO_W-1:0] err_info_i,
  input  logic                      clr_we_i,
  input  logic [NUM_SRC-1:0]        clr_data_i,
  input  logic                      mask_we_i,
  input  logic [NUM_SRC-1:0]        mask_data_i,
  output logic [NUM_SRC-1:0]        status_o,
  output logic [NUM_SRC-1:0]        mask_o,
  output logic [NUM_SRC*ADDR_W-1:0] cap_addr_o,
  output logic [NUM_SRC*INFO_W-1:0] cap_info_o,
  output logic                      irq_o
);
  logic [NUM_SRC-1:0] clr_hit;
  logic [NUM_SRC-1:0] pend;

  assign clr_hit = clr_data_i & {NUM_SRC{clr_we_i}};

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    decerr_slot #(
      .ADDR_W(ADDR_W),
      .INFO_W(INFO_W)
    ) i_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .err_i (err_i[k]),
      .addr_i(err_addr_i[k*ADDR_W +: ADDR_W]),
      .info_i(err_info_i[k*INFO_W +: INFO_W]),
      .clr_i (clr_hit[k]),
      .pend_o(pend[k]),
      .addr_o(cap_addr_o[k*ADDR_W +: ADDR_W]),
      .info_o(cap_info_o[k*INFO_W +: INFO_W])
    );
  end

  decerr_irq #(.N(NUM_SRC)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_we_i  (mask_we_i),
    .mask_data_i(mask_data_i),
    .pend_i     (pend),
    .mask_o     (mask_o),
    .irq_o      (irq_o)
  );

  assign status_o = pend;

  assert_irq_needs_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status_o & mask_o) != '0));
endmodule

// File: tb/test_decerr_capture.sv
`timescale 1ns/1ps
module test_decerr_capture;
  localparam int N  = 3;
  localparam int AW = 32;
  localparam int IW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    err_i = '0;
  logic [N*AW-1:0] err_addr_i = '0;
  logic [N*IW-1:0] err_info_i = '0;
  logic            clr_we_i = 1'b0;
  logic [N-1:0]    clr_data_i = '0;
  logic            mask_we_i = 1'b0;
  logic [N-1:0]    mask_data_i = '0;
  logic [N-1:0]    status_o, mask_o;
  logic [N*AW-1:0] cap_addr_o;
  logic [N*IW-1:0] cap_info_o;
  logic            irq_o;

  decerr_capture #(.ADDR_W(AW), .INFO_W(IW)) i_decerr_capture (.*);

  always #5 clk_i = ~clk_i;

  int n_run = 0;
  int n_fail = 0;
  int seq = 0;

  logic [N-1:0]    m_st = '0, m_mk = '0;
  logic [N*AW-1:0] m_addr = '0;
  logic [N*IW-1:0] m_info = '0;

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "status", 128'(status_o), 128'(m_st));
    chk(req, "mask", 128'(mask_o), 128'(m_mk));
    chk(req, "irq", 128'(irq_o), 128'(|(m_st & m_mk)));
    chk(req, "cap_addr", 128'(cap_addr_o), 128'(m_addr));
    chk(req, "cap_info", 128'(cap_info_o), 128'(m_info));
  endtask

  // one clock cycle of stimulus; caller is at a falling edge
  task automatic step(input logic [N-1:0] err, input logic cwe, input logic [N-1:0] cd,
                      input logic mwe, input logic [N-1:0] md, input string req);
    seq++;
    err_i = err; clr_we_i = cwe; clr_data_i = cd; mask_we_i = mwe; mask_data_i = md;
    for (int k = 0; k < N; k++) begin
      err_addr_i[k*AW +: AW] = 32'h4000_0000 + 32'(seq) * 32'h100 + 32'(k);
      err_info_i[k*IW +: IW] = 16'(seq * 7 + k * 3 + 1);
    end
    @(posedge clk_i);
    for (int k = 0; k < N; k++) begin
      if (err[k] && !m_st[k]) begin
        m_addr[k*AW +: AW] = err_addr_i[k*AW +: AW];
        m_info[k*IW +: IW] = err_info_i[k*IW +: IW];
      end
    end
    m_st = err | (m_st & ~(cd & {N{cwe}}));
    if (mwe) m_mk = md;
    @(negedge clk_i);
    compare(req);
    err_i = '0; clr_we_i = 1'b0; mask_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // sweep every mask over every error pattern
    for (int mk = 0; mk < 8; mk++) begin
      for (int pat = 0; pat < 8; pat++) begin
        step('0, 1'b1, 3'b111, 1'b0, '0, "R5");
        step('0, 1'b0, '0, 1'b1, 3'(mk), "R8");
        step(3'(pat), 1'b0, '0, 1'b0, '0, "R2 R3 R7");
        step(3'b111, 1'b0, '0, 1'b0, '0, "R4");
      end
    end

    // selective clear keeps bits written 0
    step('0, 1'b1, 3'b111, 1'b1, 3'b111, "R5");
    step(3'b111, 1'b0, '0, 1'b0, '0, "R2");
    step('0, 1'b1, 3'b010, 1'b0, '0, "R5");
    step('0, 1'b1, 3'b000, 1'b0, '0, "R5");
    // clear and error land together
    step(3'b001, 1'b1, 3'b001, 1'b0, '0, "R6");
    step(3'b010, 1'b1, 3'b111, 1'b0, '0, "R6");
    // recapture after clear
    step('0, 1'b1, 3'b111, 1'b0, '0, "R5");
    step(3'b100, 1'b0, '0, 1'b0, '0, "R9");
    step('0, 1'b1, 3'b100, 1'b0, '0, "R5");
    step(3'b100, 1'b0, '0, 1'b0, '0, "R9");
    // latch while masked, then unmask
    step('0, 1'b1, 3'b111, 1'b1, 3'b000, "R8");
    step(3'b011, 1'b0, '0, 1'b0, '0, "R8");
    step('0, 1'b0, '0, 1'b1, 3'b010, "R7");
    step('0, 1'b1, 3'b010, 1'b0, '0, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule